// File: doc/BRIEF.md
# Drawing Command Packet Parser

This block sits on the drawing-command input of a graphics engine and receives a stream of 32-bit words. It splits that stream into packets. The top byte of the first word of each packet is the opcode. A fixed per-opcode table gives the number of parameter words that follow the opcode word. When a packet completes, the block raises a one-cycle strobe that carries the opcode and the total word count. A rasteriser behind it uses this strobe to start work on the packet.

The block also handles two special opcode groups:

- **Environment opcodes.** These load a bank of eight environment registers. Some bits of those registers are copied into the low bits of a status word.
- **Rectangle copy opcodes.** These carry a position word and a size word. Once both words have arrived, the block hands them to a video-memory transfer engine.
  - A read copy returns the block to parsing at once.
  - A write copy sends the pixel words that follow straight to the transfer engine, without parsing them, until the rectangle is full.

The input uses valid/ready handshaking. Input is stalled only while a completed copy command waits for a busy transfer engine.

Top module: `gp_cmd_parser`

## Requirements
- R1: While and after synchronous reset: `in_ready` is 1, `pkt_done` and `xfer_start` are 0, `status` reads 14802000h, and environment register i reads (E0h+i) in bits 31:24 with zeros below.
- R2: A packet is 1 + N words, where N comes from the opcode in bits 31:24 of the first word:
  - 02h: N=2
  - 20h–23h: N=3
  - 24h–27h: N=6
  - 28h–2Bh: N=4
  - 2Ch–2Fh: N=8
  - 30h–33h: N=5
  - 34h–37h: N=8
  - 38h–3Bh: N=7
  - 3Ch–3Fh: N=11
  - 40h–47h: N=2
  - 48h–57h: N=3
  - 58h–5Fh: N=4
  - 60h–63h: N=2
  - 64h–67h: N=3
  - 68h–6Bh: N=1
  - 70h–73h: N=1
  - 74h–77h: N=2
  - 78h–7Bh: N=1
  - 7Ch–7Fh: N=2
  - 80h: N=3

  In the cycle after the last word is accepted, `pkt_done` is high for exactly one cycle, with `pkt_opcode` set to the opcode and `pkt_words` set to 1+N.
- R3: Any opcode not listed in R2 and outside A0h–DFh forms a single-word packet: `pkt_done` with `pkt_words`=1 in the cycle after it is accepted.
- R4: An opcode E0h–E7h stores its whole word into environment register opcode[2:0]. The value is visible on `env_rd_data` one cycle after `env_rd_idx` selects that register, counted from the write.
- R5: In the cycle after an environment write is accepted:
  - `status[10:0]` equals bits 10:0 of register 1.
  - `status[12:11]` equals bits 1:0 of register 6.

  `status[31:13]` never changes.
- R6: An opcode A0h–DFh is followed by a position word and a size word. `xfer_start` pulses once, and never before the third word has been accepted. When it pulses:
  - `xfer_pos` and `xfer_size` carry those two words.
  - `xfer_is_read` is 1 for C0h–DFh and 0 for A0h–BFh.

  `pkt_done` pulses with it, with `pkt_words`=3.
- R7: A copy command that completes while `xfer_busy` is high holds `in_ready` low and withholds `xfer_start`. `xfer_start` rises in the cycle after the first clock edge at which `xfer_busy` is low.
- R8: After a write copy starts, the next ceil(W·H/2) accepted words appear on `xfer_wr_data` with `xfer_wr_valid` one cycle after acceptance. These words raise no `pkt_done` and change no register. W and H are computed as:
  - W = ((size[9:0]−1) mod 1024)+1
  - H = ((size[24:16]−1) mod 512)+1

  Parsing resumes with the word after them.
- R9: After a read copy starts, the next accepted word is parsed as an opcode word.
- R10: While `in_valid` is low, no word is consumed. A packet split by idle cycles completes only after its last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command word valid |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Block can take a word |
| pkt_done | output | 1 | One-cycle packet-complete strobe |
| pkt_opcode | output | 8 | Opcode of the completed packet |
| pkt_words | output | 4 | Total words of the completed packet |
| env_rd_idx | input | 3 | Environment register select |
| env_rd_data | output | 32 | Registered environment register value |
| status | output | 32 | Status word |
| xfer_busy | input | 1 | Transfer engine cannot take a new command |
| xfer_start | output | 1 | One-cycle copy start strobe |
| xfer_is_read | output | 1 | Copy direction, 1 = read from video memory |
| xfer_pos | output | 32 | Copy position word |
| xfer_size | output | 32 | Copy size word |
| xfer_wr_valid | output | 1 | Pixel word valid toward the transfer engine |
| xfer_wr_data | output | 32 | Pixel word toward the transfer engine |

## Verification
A wrong remaining-word count or a wrong state misaligns every later packet. The first effect is a `pkt_done` strobe that comes early or late, or carries the wrong opcode, usually within one packet of the fault. A wrong write-copy length shows up at the first word after the rectangle: a pixel word is taken as an opcode, or an opcode is forwarded as a pixel word. The bench probes this with a full-width single-row copy, where the width field wraps. Environment and status faults appear on the read port and on `status` one cycle after the write.

// File: rtl/gpcp_pkg.sv
package gpcp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BODY,
    ST_HDR,
    ST_HAND,
    ST_WDATA
  } gpcp_state_t;

  // number of parameter words after the opcode word
  function automatic logic [3:0] extra_words(input logic [7:0] op);
    logic [3:0] n;
    n = 4'd0;
    if (op == 8'h02)                 n = 4'd2;
    else if (op inside {[8'h20:8'h23]}) n = 4'd3;
    else if (op inside {[8'h24:8'h27]}) n = 4'd6;
    else if (op inside {[8'h28:8'h2B]}) n = 4'd4;
    else if (op inside {[8'h2C:8'h2F]}) n = 4'd8;
    else if (op inside {[8'h30:8'h33]}) n = 4'd5;
    else if (op inside {[8'h34:8'h37]}) n = 4'd8;
    else if (op inside {[8'h38:8'h3B]}) n = 4'd7;
    else if (op inside {[8'h3C:8'h3F]}) n = 4'd11;
    else if (op inside {[8'h40:8'h47]}) n = 4'd2;
    else if (op inside {[8'h48:8'h57]}) n = 4'd3;
    else if (op inside {[8'h58:8'h5F]}) n = 4'd4;
    else if (op inside {[8'h60:8'h63]}) n = 4'd2;
    else if (op inside {[8'h64:8'h67]}) n = 4'd3;
    else if (op inside {[8'h68:8'h6B]}) n = 4'd1;
    else if (op inside {[8'h70:8'h73]}) n = 4'd1;
    else if (op inside {[8'h74:8'h77]}) n = 4'd2;
    else if (op inside {[8'h78:8'h7B]}) n = 4'd1;
    else if (op inside {[8'h7C:8'h7F]}) n = 4'd2;
    else if (op == 8'h80)            n = 4'd3;
    else if (op == 8'hA0 || op == 8'hC0) n = 4'd2;
    return n;
  endfunction

endpackage

// File: rtl/gpcp_len_decode.sv
module gpcp_len_decode
  import gpcp_pkg::*;
(
  input  logic [7:0] opcode,
  output logic [3:0] extra,
  output logic       is_copy,
  output logic       is_copy_read,
  output logic       is_env
);
  always_comb begin
    extra        = extra_words(opcode);
    is_copy      = (opcode >= 8'hA0) && (opcode <= 8'hDF);
    is_copy_read = (opcode[7:5] == 3'b110);
    is_env       = (opcode[7:3] == 5'b11100);
  end
endmodule

// File: rtl/gpcp_env_bank.sv
module gpcp_env_bank #(
  parameter int NUM_ENV      = 8,
  parameter int DW           = 32,
  parameter logic [31:0] STATUS_RESET = 32'h1480_2000,
  localparam int IW          = $clog2(NUM_ENV)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic [31:0]   status
);
  logic [DW-1:0] regs [NUM_ENV];

  for (genvar i = 0; i < NUM_ENV; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= {8'(8'hE0 + i), {(DW-8){1'b0}}};
      else if (wr_en && wr_idx == IW'(i))
        regs[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= regs[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= STATUS_RESET;
    end else if (wr_en) begin
      if (wr_idx == IW'(1)) status[10:0]  <= wr_data[10:0];
      if (wr_idx == IW'(6)) status[12:11] <= wr_data[1:0];
    end
  end
endmodule

// File: rtl/gpcp_copy_count.sv
module gpcp_copy_count #(
  parameter int XB = 10,
  parameter int YB = 9,
  localparam int PW = XB + YB + 2,
  localparam int CW = PW
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [31:0] size_word,
  input  logic        step,
  output logic        last
);
  logic [XB:0]   w;
  logic [YB:0]   h;
  logic [PW-1:0] px;
  logic [CW-1:0] words, cnt_q;

  always_comb begin
    w     = {1'b0, size_word[XB-1:0] - XB'(1)} + (XB+1)'(1);
    h     = {1'b0, size_word[16+YB-1:16] - YB'(1)} + (YB+1)'(1);
    px    = PW'(w) * PW'(h);
    words = (px + PW'(1)) >> 1;
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= words;
    else if (step) cnt_q <= cnt_q - CW'(1);
  end

  assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/gp_cmd_parser.sv
module gp_cmd_parser
  import gpcp_pkg::*;
#(
  parameter int DW      = 32,
  parameter int NUM_ENV = 8,
  parameter int XB      = 10,
  parameter int YB      = 9,
  localparam int IW     = $clog2(NUM_ENV)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          pkt_done,
  output logic [7:0]    pkt_opcode,
  output logic [3:0]    pkt_words,
  input  logic [IW-1:0] env_rd_idx,
  output logic [DW-1:0] env_rd_data,
  output logic [31:0]   status,
  input  logic          xfer_busy,
  output logic          xfer_start,
  output logic          xfer_is_read,
  output logic [DW-1:0] xfer_pos,
  output logic [DW-1:0] xfer_size,
  output logic          xfer_wr_valid,
  output logic [DW-1:0] xfer_wr_data
);
  gpcp_state_t state_q;
  logic [7:0]  cur_op_q;
  logic [3:0]  left_q, total_q;
  logic        hdr_second_q;

  logic [7:0]  op_in;
  logic [3:0]  extra;
  logic        is_copy, is_copy_read, is_env;
  logic        accept, env_wr, cnt_load, cnt_step, cnt_last;

  assign op_in    = in_data[DW-1:DW-8];
  assign in_ready = (state_q != ST_HAND);
  assign accept   = in_valid && in_ready;
  assign env_wr   = (state_q == ST_IDLE) && accept && is_env;
  assign cnt_load = (state_q == ST_HAND) && !xfer_busy && !xfer_is_read;
  assign cnt_step = (state_q == ST_WDATA) && accept;

  gpcp_len_decode u_dec (
    .opcode(op_in), .extra(extra), .is_copy(is_copy),
    .is_copy_read(is_copy_read), .is_env(is_env)
  );

  gpcp_env_bank #(.NUM_ENV(NUM_ENV), .DW(DW)) u_env (
    .clk(clk), .rst(rst), .wr_en(env_wr), .wr_idx(op_in[IW-1:0]),
    .wr_data(in_data), .rd_idx(env_rd_idx), .rd_data(env_rd_data),
    .status(status)
  );

  gpcp_copy_count #(.XB(XB), .YB(YB)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .size_word(xfer_size),
    .step(cnt_step), .last(cnt_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      cur_op_q      <= '0;
      left_q        <= '0;
      total_q       <= '0;
      hdr_second_q  <= 1'b0;
      pkt_done      <= 1'b0;
      pkt_opcode    <= '0;
      pkt_words     <= '0;
      xfer_start    <= 1'b0;
      xfer_is_read  <= 1'b0;
      xfer_pos      <= '0;
      xfer_size     <= '0;
      xfer_wr_valid <= 1'b0;
      xfer_wr_data  <= '0;
    end else begin
      pkt_done      <= 1'b0;
      xfer_start    <= 1'b0;
      xfer_wr_valid <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          cur_op_q <= op_in;
          if (is_copy) begin
            state_q      <= ST_HDR;
            hdr_second_q <= 1'b0;
            xfer_is_read <= is_copy_read;
          end else if (extra == 4'd0) begin
            pkt_done   <= 1'b1;
            pkt_opcode <= op_in;
            pkt_words  <= 4'd1;
          end else begin
            state_q <= ST_BODY;
            left_q  <= extra;
            total_q <= extra + 4'd1;
          end
        end
        ST_BODY: if (accept) begin
          if (left_q == 4'd1) begin
            pkt_done   <= 1'b1;
            pkt_opcode <= cur_op_q;
            pkt_words  <= total_q;
            state_q    <= ST_IDLE;
          end else begin
            left_q <= left_q - 4'd1;
          end
        end
        ST_HDR: if (accept) begin
          if (!hdr_second_q) begin
            xfer_pos     <= in_data;
            hdr_second_q <= 1'b1;
          end else begin
            xfer_size <= in_data;
            state_q   <= ST_HAND;
          end
        end
        ST_HAND: if (!xfer_busy) begin
          xfer_start <= 1'b1;
          pkt_done   <= 1'b1;
          pkt_opcode <= cur_op_q;
          pkt_words  <= 4'd3;
          state_q    <= xfer_is_read ? ST_IDLE : ST_WDATA;
        end
        ST_WDATA: if (accept) begin
          xfer_wr_valid <= 1'b1;
          xfer_wr_data  <= in_data;
          if (cnt_last) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gp_cmd_parser_chk.sv
module gp_cmd_parser_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        pkt_done,
  input logic [3:0]  pkt_words,
  input logic [31:0] status,
  input logic        xfer_busy,
  input logic        xfer_start,
  input logic        xfer_wr_valid
);
  // R7: a copy start only follows a cycle with the engine free
  assert_start_when_free_R7: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> $past(!xfer_busy));

  // R7: stalled while busy means no start next cycle
  assert_hold_while_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && xfer_busy) |=> !xfer_start);

  // R5: upper status bits are fixed
  assert_status_upper_R5: assert property (@(posedge clk) disable iff (rst)
    $stable(status[31:13]));

  // R2: packet sizes stay within the table range
  assert_words_range_R2: assert property (@(posedge clk) disable iff (rst)
    pkt_done |-> (pkt_words >= 4'd1 && pkt_words <= 4'd12));

  // R2: a non-copy completion follows an accepted word
  assert_done_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (pkt_done && !xfer_start) |-> $past(in_valid && in_ready));

  // R8: pixel words raise no packet strobe and follow an accept
  assert_pixel_no_done_R8: assert property (@(posedge clk) disable iff (rst)
    xfer_wr_valid |-> (!pkt_done && $past(in_valid && in_ready)));
endmodule

bind gp_cmd_parser gp_cmd_parser_chk chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .pkt_done(pkt_done), .pkt_words(pkt_words), .status(status),
  .xfer_busy(xfer_busy), .xfer_start(xfer_start),
  .xfer_wr_valid(xfer_wr_valid)
);

// File: tb/gp_cmd_parser_tb_top.sv
`timescale 1ns/1ps
module gp_cmd_parser_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        pkt_done;
  logic [7:0]  pkt_opcode;
  logic [3:0]  pkt_words;
  logic [2:0]  env_rd_idx = '0;
  logic [31:0] env_rd_data;
  logic [31:0] status;
  logic        xfer_busy = 1'b0;
  logic        xfer_start, xfer_is_read, xfer_wr_valid;
  logic [31:0] xfer_pos, xfer_size, xfer_wr_data;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  gp_cmd_parser dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .pkt_done(pkt_done), .pkt_opcode(pkt_opcode),
    .pkt_words(pkt_words), .env_rd_idx(env_rd_idx), .env_rd_data(env_rd_data),
    .status(status), .xfer_busy(xfer_busy), .xfer_start(xfer_start),
    .xfer_is_read(xfer_is_read), .xfer_pos(xfer_pos), .xfer_size(xfer_size),
    .xfer_wr_valid(xfer_wr_valid), .xfer_wr_data(xfer_wr_data)
  );

  // {opcode, expected total words}
  localparam logic [11:0] TBL [18] = '{
    {8'h02, 4'd3},  {8'h20, 4'd4},  {8'h27, 4'd7},  {8'h2A, 4'd5},
    {8'h2C, 4'd9},  {8'h31, 4'd6},  {8'h36, 4'd9},  {8'h3B, 4'd8},
    {8'h3E, 4'd12}, {8'h44, 4'd3},  {8'h50, 4'd4},  {8'h5F, 4'd5},
    {8'h62, 4'd3},  {8'h65, 4'd4},  {8'h68, 4'd2},  {8'h7C, 4'd3},
    {8'h80, 4'd4},  {8'h01, 4'd1}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic read_env(input int idx, output logic [31:0] v);
    @(negedge clk);
    env_rd_idx = 3'(idx);
    tick();
    v = env_rd_data;
  endtask

  initial begin
    #500000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired actual=%08h expected=%08h", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic        seen;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check(in_ready == 1'b1, "R1 ready", 32'(in_ready), 1);
    check(pkt_done == 1'b0 && xfer_start == 1'b0, "R1 strobes", 32'(pkt_done), 0);
    check(status == 32'h1480_2000, "R1 status", status, 32'h1480_2000);
    for (int i = 0; i < 8; i++) begin
      read_env(i, v);
      check(v == {8'(8'hE0 + i), 24'h0}, "R1 env reset", v, {8'(8'hE0 + i), 24'h0});
    end

    // R2 / R3 table walk
    for (int k = 0; k < 18; k++) begin
      logic [7:0] op;
      logic [3:0] n;
      op = TBL[k][11:4];
      n  = TBL[k][3:0];
      put({op, 24'h00_1234});
      for (int j = 1; j < int'(n); j++) begin
        if (j == int'(n) - 1 || n == 4'd1) ; else ;
        check(pkt_done == 1'b0, "R2 no early done", 32'(pkt_done), 0);
        put(32'h1111_0000 + 32'(j));
      end
      check(pkt_done && pkt_opcode == op && pkt_words == n,
            (n == 4'd1) ? "R3 single packet" : "R2 packet length",
            {20'h0, pkt_opcode, pkt_words}, {20'h0, op, n});
    end

    // R10 stall mid-packet: 0x28 takes 5 words
    put(32'h2800_0000);
    repeat (3) begin
      tick();
      check(pkt_done == 1'b0, "R10 idle no done", 32'(pkt_done), 0);
    end
    put(32'h1); put(32'h2); put(32'h3);
    check(pkt_done == 1'b0, "R10 not yet", 32'(pkt_done), 0);
    tick();
    check(pkt_done == 1'b0, "R10 idle before last", 32'(pkt_done), 0);
    put(32'h4);
    check(pkt_done && pkt_opcode == 8'h28 && pkt_words == 4'd5, "R10 completes",
          {24'h0, pkt_opcode}, 32'h28);

    // R4 / R5 environment writes
    @(negedge clk); env_rd_idx = 3'd5;
    put(32'hE5AB_CDEF);
    check(pkt_done && pkt_words == 4'd1, "R3 env single", 32'(pkt_words), 1);
    tick();
    check(env_rd_data == 32'hE5AB_CDEF, "R4 env store", env_rd_data, 32'hE5AB_CDEF);
    put(32'hE1AB_C5A5);
    check(status == 32'h1480_25A5, "R5 status env1", status, 32'h1480_25A5);
    put(32'hE600_0003);
    check(status == 32'h1480_3DA5, "R5 status env6", status, 32'h1480_3DA5);

    // R6 / R8 write copy: w=3, h=1 -> 2 words
    put(32'hA000_0000);
    put(32'h0010_0020);
    put(32'h0001_0003);
    check(xfer_start == 1'b0, "R6 not before third", 32'(xfer_start), 0);
    tick();
    check(xfer_start && !xfer_is_read && xfer_pos == 32'h0010_0020 &&
          xfer_size == 32'h0001_0003, "R6 write start", xfer_pos, 32'h0010_0020);
    check(pkt_done && pkt_opcode == 8'hA0 && pkt_words == 4'd3, "R6 copy done",
          {24'h0, pkt_opcode}, 32'hA0);
    tick();
    check(xfer_start == 1'b0, "R6 single pulse", 32'(xfer_start), 0);
    put(32'hE100_0111);
    check(xfer_wr_valid && xfer_wr_data == 32'hE100_0111 && !pkt_done,
          "R8 pixel word 1", xfer_wr_data, 32'hE100_0111);
    put(32'hE100_0222);
    check(xfer_wr_valid && xfer_wr_data == 32'hE100_0222 && !pkt_done,
          "R8 pixel word 2", xfer_wr_data, 32'hE100_0222);
    check(status == 32'h1480_3DA5, "R8 status untouched", status, 32'h1480_3DA5);
    put(32'h0200_0000);
    check(xfer_wr_valid == 1'b0 && pkt_done == 1'b0, "R8 parse resumes",
          32'(xfer_wr_valid), 0);
    put(32'h0); put(32'h0);
    check(pkt_done && pkt_opcode == 8'h02, "R8 next packet", {24'h0, pkt_opcode}, 32'h02);

    // R8 width wrap: size 00010000h -> w=1024, h=1 -> 512 words
    put(32'hBF00_0000); put(32'h0); put(32'h0001_0000);
    tick();
    check(xfer_start && !xfer_is_read, "R6 BF is write", 32'(xfer_is_read), 0);
    seen = 1'b0;
    for (int j = 0; j < 512; j++) begin
      put(32'hE200_0000 | 32'(j));
      if (pkt_done || !xfer_wr_valid) seen = 1'b1;
    end
    check(!seen, "R8 512 pixel words", 32'(seen), 0);
    put(32'hE200_0123);
    check(pkt_done && pkt_opcode == 8'hE2 && !xfer_wr_valid, "R8 wrap count",
          {24'h0, pkt_opcode}, 32'hE2);

    // R7 / R9 read copy with busy engine
    @(negedge clk); xfer_busy = 1'b1;
    put(32'hC000_0000); put(32'h0005_0006); put(32'h0004_0004);
    repeat (3) begin
      tick();
      check(!in_ready && !xfer_start, "R7 held while busy", 32'(xfer_start), 0);
    end
    @(negedge clk); xfer_busy = 1'b0;
    tick();
    check(xfer_start && xfer_is_read && xfer_size == 32'h0004_0004,
          "R7 start after busy", xfer_size, 32'h0004_0004);
    check(in_ready == 1'b1, "R7 ready again", 32'(in_ready), 1);
    put(32'h6800_0000); put(32'h9);
    check(pkt_done && pkt_opcode == 8'h68 && pkt_words == 4'd2 && !xfer_wr_valid,
          "R9 parse after read", {24'h0, pkt_opcode}, 32'h68);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule